// File: doc/BRIEF.md
# Flash Segment Write-Protect Guard

This block sits in front of a flash programming engine and decides, for each write or erase request, whether the target word address may be modified. Program memory is organised as pages of 512 words. A protected segment is described by a small set of settings. A disable bit switches the segment off. A direction bit selects whether the segment reaches down to address zero or up to the end of memory. A boundary page number fixes the segment's edge, and that page is always part of the segment. A separate last-page bit guards the final implemented page on its own, whatever the other settings are.

The settings and the implemented memory size are captured once after reset, on the first load strobe. Any later load strobe is ignored until the next reset. Each request is judged in the cycle after its valid strobe. The block then pulses either a grant or a violation for that request. Any violation also raises a sticky error bit. Only reset or an explicit clear input lowers that bit.

Top module: `flash_wp_guard`

## Requirements
- R1: After reset, `grant`, `violation` and `err_sticky` are all 0.
- R2: A request sampled with `req_valid`=1 on one rising edge produces, on the following edge, exactly one of `grant` or `violation` for one cycle. A cycle without a request produces neither.
- R3: With `cfg_seg_off`=1 (segment disabled) and `cfg_keep_last`=1 (last page unguarded), every address is granted.
- R4: With `cfg_seg_off`=0 and `cfg_up_dir`=0, addresses from 0 through `cfg_bound_page`*512+511 inclusive are denied. Higher addresses are granted, unless R6 applies.
- R5: With `cfg_seg_off`=0 and `cfg_up_dir`=1, addresses from `cfg_bound_page`*512 upward are denied. Lower addresses are granted, unless R6 applies.
- R6: With `cfg_keep_last`=0, every address in page (`mem_words`/512)−1 is denied, whatever the other settings are, including `cfg_seg_off`=1.
- R7: A violation sets `err_sticky` on the same edge that raises `violation`. The bit then stays 1 through later granted requests.
- R8: `err_clr`=1 clears `err_sticky` on the next edge. If a denied request is sampled on that same edge, the bit stays 1.
- R9: Settings and `mem_words` are captured from the first `cfg_load` pulse after reset. Later pulses have no effect until reset.
- R10: Any request made before settings have been captured is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture strobe for the settings |
| cfg_seg_off | input | 1 | 1 disables the segment |
| cfg_up_dir | input | 1 | 0: segment reaches down to 0; 1: segment reaches up to top |
| cfg_keep_last | input | 1 | 0 guards the last implemented page |
| cfg_bound_page | input | PAGE_NUM_W | Boundary page, included in the segment |
| mem_words | input | ADDR_W+1 | Implemented memory size in words |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Word address of the request |
| err_clr | input | 1 | Clears the sticky error |
| grant | output | 1 | Request allowed (one-cycle pulse) |
| violation | output | 1 | Request refused (one-cycle pulse) |
| err_sticky | output | 1 | Latched violation indicator |

## Verification
The bench builds the block with its default widths: a 9-bit page number and 9-bit page offset, which gives an 18-bit word address. It drives an implemented size of 131072 words, so the last implemented page (255) lies well below the largest encodable page. That keeps the last-page rule separate from the segment's upward reach and from the page-field limit. The boundary pages are chosen so that the words just inside and just outside each inclusive edge can be probed.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
    localparam int unsigned FWP_PAGE_NUM_W_DEF = 9;
    localparam int unsigned FWP_PAGE_OFS_W_DEF = 9;

    typedef struct packed {
        logic seg_off;
        logic up_dir;
        logic keep_last;
    } fwp_mode_t;

    typedef enum logic [1:0] {
        FWP_IDLE  = 2'd0,
        FWP_GRANT = 2'd1,
        FWP_DENY  = 2'd2
    } fwp_verdict_e;

    localparam fwp_mode_t FWP_MODE_RESET = '{seg_off: 1'b1, up_dir: 1'b1, keep_last: 1'b1};

    function automatic fwp_verdict_e fwp_judge(input logic valid, input logic hit);
        if (!valid)   return FWP_IDLE;
        else if (hit) return FWP_DENY;
        else          return FWP_GRANT;
    endfunction
endpackage

// File: rtl/fwp_cfg_hold.sv
module fwp_cfg_hold
    import fwp_pkg::*;
#(
    parameter int unsigned PAGE_NUM_W = FWP_PAGE_NUM_W_DEF,
    parameter int unsigned ADDR_W     = 18
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  fwp_mode_t             mode_in,
    input  logic [PAGE_NUM_W-1:0] page_in,
    input  logic [ADDR_W:0]       size_in,
    output fwp_mode_t             mode_q,
    output logic [PAGE_NUM_W-1:0] page_q,
    output logic [ADDR_W:0]       size_q,
    output logic                  armed_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            mode_q  <= FWP_MODE_RESET;
            page_q  <= '0;
            size_q  <= '0;
        end else if (load && !armed_q) begin
            armed_q <= 1'b1;
            mode_q  <= mode_in;
            page_q  <= page_in;
            size_q  <= size_in;
        end
    end
endmodule

// File: rtl/fwp_range_decode.sv
module fwp_range_decode
    import fwp_pkg::*;
#(
    parameter int unsigned PAGE_NUM_W = FWP_PAGE_NUM_W_DEF,
    parameter int unsigned PAGE_OFS_W = FWP_PAGE_OFS_W_DEF,
    localparam int unsigned ADDR_W    = PAGE_NUM_W + PAGE_OFS_W
) (
    input  logic                  armed,
    input  fwp_mode_t             mode,
    input  logic [PAGE_NUM_W-1:0] bound_page,
    input  logic [ADDR_W:0]       size_words,
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit
);
    logic [PAGE_NUM_W-1:0] req_page;
    logic [PAGE_NUM_W:0]   last_page;
    logic                  in_seg;
    logic                  in_last;

    always_comb begin
        req_page  = addr[ADDR_W-1:PAGE_OFS_W];
        last_page = size_words[ADDR_W:PAGE_OFS_W] - 1'b1;
        if (mode.seg_off)     in_seg = 1'b0;
        else if (mode.up_dir) in_seg = (req_page >= bound_page);
        else                  in_seg = (req_page <= bound_page);
        in_last = !mode.keep_last && ({1'b0, req_page} == last_page);
        hit     = !armed || in_seg || in_last;
    end
endmodule

// File: rtl/fwp_resp.sv
module fwp_resp
    import fwp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic hit,
    input  logic err_clr,
    output logic grant,
    output logic violation,
    output logic err_sticky
);
    fwp_verdict_e verdict_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q  <= FWP_IDLE;
            err_sticky <= 1'b0;
        end else begin
            verdict_q <= fwp_judge(req_valid, hit);
            if (req_valid && hit) err_sticky <= 1'b1;
            else if (err_clr)     err_sticky <= 1'b0;
        end
    end

    assign grant     = (verdict_q == FWP_GRANT);
    assign violation = (verdict_q == FWP_DENY);
endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
    import fwp_pkg::*;
#(
    parameter int unsigned PAGE_NUM_W = FWP_PAGE_NUM_W_DEF,
    parameter int unsigned PAGE_OFS_W = FWP_PAGE_OFS_W_DEF,
    localparam int unsigned ADDR_W    = PAGE_NUM_W + PAGE_OFS_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_load,
    input  logic                  cfg_seg_off,
    input  logic                  cfg_up_dir,
    input  logic                  cfg_keep_last,
    input  logic [PAGE_NUM_W-1:0] cfg_bound_page,
    input  logic [ADDR_W:0]       mem_words,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  err_clr,
    output logic                  grant,
    output logic                  violation,
    output logic                  err_sticky
);
    fwp_mode_t             mode_in;
    fwp_mode_t             mode_q;
    logic [PAGE_NUM_W-1:0] page_q;
    logic [ADDR_W:0]       size_q;
    logic                  armed_q;
    logic                  hit;

    assign mode_in = '{seg_off: cfg_seg_off, up_dir: cfg_up_dir, keep_last: cfg_keep_last};

    fwp_cfg_hold #(.PAGE_NUM_W(PAGE_NUM_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst(rst), .load(cfg_load),
        .mode_in(mode_in), .page_in(cfg_bound_page), .size_in(mem_words),
        .mode_q(mode_q), .page_q(page_q), .size_q(size_q), .armed_q(armed_q)
    );

    fwp_range_decode #(.PAGE_NUM_W(PAGE_NUM_W), .PAGE_OFS_W(PAGE_OFS_W)) u_dec (
        .armed(armed_q), .mode(mode_q), .bound_page(page_q),
        .size_words(size_q), .addr(req_addr), .hit(hit)
    );

    fwp_resp u_resp (
        .clk(clk), .rst(rst), .req_valid(req_valid), .hit(hit), .err_clr(err_clr),
        .grant(grant), .violation(violation), .err_sticky(err_sticky)
    );
endmodule

// File: rtl/fwp_guard_checker.sv
module fwp_guard_checker #(
    parameter int unsigned PAGE_NUM_W = 9
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  err_clr,
    input logic                  grant,
    input logic                  violation,
    input logic                  err_sticky,
    input logic                  armed_q,
    input logic [PAGE_NUM_W-1:0] page_q
);
    assert_excl_R2: assert property (@(posedge clk) disable iff (rst) !(grant && violation));
    assert_answer_R2: assert property (@(posedge clk) disable iff (rst) req_valid |=> (grant || violation));
    assert_quiet_R2: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !(grant || violation));
    assert_sticky_set_R7: assert property (@(posedge clk) disable iff (rst) violation |-> err_sticky);
    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst) (err_sticky && !err_clr) |=> err_sticky);
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst) (err_clr && !req_valid) |=> !err_sticky);
    assert_frozen_R9: assert property (@(posedge clk) disable iff (rst) armed_q |=> (armed_q && $stable(page_q)));
    assert_unarmed_deny_R10: assert property (@(posedge clk) disable iff (rst) (!armed_q && req_valid) |=> violation);
endmodule

bind flash_wp_guard fwp_guard_checker #(.PAGE_NUM_W(PAGE_NUM_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .err_clr(err_clr),
    .grant(grant), .violation(violation), .err_sticky(err_sticky),
    .armed_q(armed_q), .page_q(page_q)
);

// File: tb/flash_wp_guard_bench.sv
module flash_wp_guard_bench;
    localparam int PN_W = 9;
    localparam int AW   = 18;
    localparam int MEMW = 131072;
    localparam int LASTP = MEMW / 512 - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_load = 1'b0;
    logic            cfg_seg_off = 1'b1;
    logic            cfg_up_dir = 1'b1;
    logic            cfg_keep_last = 1'b1;
    logic [PN_W-1:0] cfg_bound_page = '0;
    logic [AW:0]     mem_words = MEMW[AW:0];
    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic            err_clr = 1'b0;
    logic            grant, violation, err_sticky;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_wp_guard u_flash_wp_guard (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_seg_off(cfg_seg_off),
        .cfg_up_dir(cfg_up_dir), .cfg_keep_last(cfg_keep_last),
        .cfg_bound_page(cfg_bound_page), .mem_words(mem_words),
        .req_valid(req_valid), .req_addr(req_addr), .err_clr(err_clr),
        .grant(grant), .violation(violation), .err_sticky(err_sticky)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; err_clr = 1'b0; cfg_load = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_load(input logic off, input logic up, input logic keep, input int page);
        @(negedge clk);
        cfg_seg_off = off; cfg_up_dir = up; cfg_keep_last = keep;
        cfg_bound_page = page[PN_W-1:0]; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic do_req(input int addr, input logic deny, input string req);
        @(negedge clk);
        req_addr = addr[AW-1:0]; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, violation, deny);
        check(req, grant, !deny);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 grant", grant, 1'b0);
        check("R1 violation", violation, 1'b0);
        check("R1 err", err_sticky, 1'b0);
        do_req(1000, 1'b1, "R10 unloaded");
        @(negedge clk);
        check("R2 idle grant", grant, 1'b0);
        check("R2 idle violation", violation, 1'b0);
    endtask

    task automatic t_disabled();
        do_reset();
        do_load(1'b1, 1'b0, 1'b1, 5);
        do_req(0, 1'b0, "R3 addr0");
        do_req(5 * 512, 1'b0, "R3 bound");
        do_req(LASTP * 512 + 511, 1'b0, "R3 top");
        check("R3 err", err_sticky, 1'b0);
    endtask

    task automatic t_down_and_sticky();
        do_reset();
        do_load(1'b0, 1'b0, 1'b1, 10);
        do_req(0, 1'b1, "R4 addr0");
        do_req(10 * 512 + 511, 1'b1, "R4 bound last word");
        check("R7 set", err_sticky, 1'b1);
        do_req(11 * 512, 1'b0, "R4 above bound");
        do_req(LASTP * 512, 1'b0, "R4 last page open");
        check("R7 hold", err_sticky, 1'b1);
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R8 clear", err_sticky, 1'b0);
        @(negedge clk);
        req_addr = 18'd3; req_valid = 1'b1; err_clr = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; err_clr = 1'b0;
        check("R8 set wins", err_sticky, 1'b1);
    endtask

    task automatic t_up();
        do_reset();
        do_load(1'b0, 1'b1, 1'b1, 200);
        do_req(200 * 512 - 1, 1'b0, "R5 below bound");
        do_req(200 * 512, 1'b1, "R5 bound first word");
        do_req(MEMW - 1, 1'b1, "R5 top word");
        // later load must not reopen the segment
        do_load(1'b1, 1'b0, 1'b1, 0);
        do_req(200 * 512, 1'b1, "R9 reload ignored");
        do_req(199 * 512, 1'b0, "R9 reload ignored low");
    endtask

    task automatic t_last_page();
        do_reset();
        do_load(1'b1, 1'b1, 1'b0, 0);
        do_req(LASTP * 512, 1'b1, "R6 last page first");
        do_req(LASTP * 512 - 1, 1'b0, "R6 page below last");
        do_reset();
        do_load(1'b0, 1'b0, 1'b0, 3);
        do_req(LASTP * 512 + 511, 1'b1, "R6 with down segment");
        do_req(100 * 512, 1'b0, "R6 middle open");
        do_req(3 * 512 + 7, 1'b1, "R4 with last guard");
    endtask

    initial begin
        t_reset_state();
        t_disabled();
        t_down_and_sticky();
        t_up();
        t_last_page();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule